// File: doc/BRIEF.md
# Summary interrupt cause aggregator

This block sits between three interrupt source groups (receive, transmit and miscellaneous) and the single host interrupt line. Each group controller already applies its own cause and mask logic and presents one level request. The aggregator latches those requests into a three-bit summary cause register, gates the summary through a software mask register, and drives a registered, glitch-free interrupt line.

Host software reads the summary register to find which groups need service. The read itself acknowledges the summary, so no write is needed. To keep the line quiet while groups are serviced, software sets every mask bit. To re-enable the line, it writes a value that has zeros in the three group positions and ones in every other position. A request that is still asserted sets its summary bit again on the next clock, so a level that was not serviced is not lost.

Top module: `aic_pseudo_cause`

## Requirements
- R1: After reset the summary register reads 0, the mask register reads all ones (0xFFFFFFFF), and irq_o is low.
- R2: A high grp_irq_i bit sets the matching summary bit at the next clock edge. Summary bit 0 is receive, bit 1 is transmit and bit 2 is miscellaneous. Summary bits above bit 2 read as zero.
- R3: A read of the summary address (addr_i = 0) returns the current summary value and clears it at the same clock edge. Any group whose request is still high sets its bit again.
- R4: A group request present in the same cycle as a clearing read is kept in the summary register after that read.
- R5: A write to the mask address (addr_i = 1) stores the full 32-bit wdata_i. A read of that address returns it.
- R6: irq_o is a register. It goes high one clock after any summary bit is set while its mask bit (mask bit g for group g) is zero, and it goes low one clock after no unmasked summary bit remains.
- R7: While mask bits 2:0 are all ones, irq_o stays low even with summary bits pending.
- R8: Only mask bits 2:0 gate the line. A mask value of 0xFFFFFFF8 enables all three groups, while bits 31:3 have no effect on irq_o.
- R9: Writes to the summary address are ignored and leave the summary value unchanged.
- R10: Addresses 2 and 3 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_irq_i | input | 3 | Level requests: bit 0 receive, bit 1 transmit, bit 2 miscellaneous |
| req_i | input | 1 | Register access strobe, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register word address: 0 = summary, 1 = mask |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, valid in the same cycle as the access |
| irq_o | output | 1 | Registered host interrupt line |

## Verification
A summary bit that is stuck or lost shows up on the very next summary read. It appears as a wrong rdata_o value, or as a second read that is not zero. An interrupt line that follows stale or wrong mask state shows up two clocks after a group request pulse, which is when irq_o must settle. The bench aims at the hazard cases: a request arriving in the same cycle as a clearing read, partial masks, writes to the read-only summary, and held levels that must reappear after every read. Each of these leaves a wrong value at the ports within one or two cycles.

// File: rtl/aic_pkg.sv
package aic_pkg;
  localparam int NG       = 3;
  localparam int GRP_RX   = 0;
  localparam int GRP_TX   = 1;
  localparam int GRP_MISC = 2;
endpackage

// File: rtl/aic_sum_reg.sv
module aic_sum_reg #(
  parameter int NG = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NG-1:0] set_i,
  input  logic          clr_i,
  output logic [NG-1:0] sum_o
);
  for (genvar g = 0; g < NG; g++) begin : g_bit
    // set wins over clear so a coincident event survives the read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sum_o[g] <= 1'b0;
      else if (set_i[g]) sum_o[g] <= 1'b1;
      else if (clr_i)    sum_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/aic_mask_reg.sv
module aic_mask_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '1;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/aic_irq_gen.sv
module aic_irq_gen #(
  parameter int NG = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NG-1:0] sum_i,
  input  logic [NG-1:0] mask_i,
  output logic          irq_o
);
  logic irq_d;

  assign irq_d = |(sum_i & ~mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end
endmodule

// File: rtl/aic_pseudo_cause.sv
module aic_pseudo_cause
  import aic_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 2,
  parameter int SUM_ADDR  = 0,
  parameter int MASK_ADDR = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NG-1:0] grp_irq_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic          sel_sum, sel_mask;
  logic          rd_sum, wr_mask;
  logic [NG-1:0] sum_q;
  logic [DW-1:0] mask_q;

  assign sel_sum  = (addr_i == AW'(SUM_ADDR));
  assign sel_mask = (addr_i == AW'(MASK_ADDR));
  assign rd_sum   = req_i && !we_i && sel_sum;
  assign wr_mask  = req_i &&  we_i && sel_mask;

  aic_sum_reg #(.NG(NG)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (grp_irq_i),
    .clr_i  (rd_sum),
    .sum_o  (sum_q)
  );

  aic_mask_reg #(.DW(DW)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_mask),
    .wdata_i (wdata_i),
    .mask_o  (mask_q)
  );

  aic_irq_gen #(.NG(NG)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sum_i  (sum_q),
    .mask_i (mask_q[NG-1:0]),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_sum)       rdata_o[NG-1:0] = sum_q;
    else if (sel_mask) rdata_o = mask_q;
  end
endmodule

// File: rtl/aic_pseudo_cause_chk.sv
module aic_pseudo_cause_chk #(
  parameter int NG        = 3,
  parameter int DW        = 32,
  parameter int AW        = 2,
  parameter int SUM_ADDR  = 0,
  parameter int MASK_ADDR = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NG-1:0] grp_irq_i,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          irq_o,
  input logic [NG-1:0] sum_q,
  input logic [DW-1:0] mask_q
);
  // R2 and R4: every asserted request is present after the edge, read or not
  p_set_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_irq_i != '0) |=> ((sum_q & $past(grp_irq_i)) == $past(grp_irq_i)));

  p_read_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == AW'(SUM_ADDR) && grp_irq_i == '0) |=> (sum_q == '0));

  p_mask_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(MASK_ADDR)) |=> (mask_q == $past(wdata_i)));

  p_irq_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(sum_q & ~mask_q[NG-1:0]))));

  p_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q[NG-1:0]) |=> !irq_o);

  p_sum_wr_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(SUM_ADDR) && grp_irq_i == '0) |=> (sum_q == $past(sum_q)));
endmodule

bind aic_pseudo_cause aic_pseudo_cause_chk #(
  .NG(aic_pkg::NG), .DW(DW), .AW(AW), .SUM_ADDR(SUM_ADDR), .MASK_ADDR(MASK_ADDR)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .grp_irq_i (grp_irq_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .sum_q     (sum_q),
  .mask_q    (mask_q)
);

// File: tb/aic_pseudo_cause_tb_top.sv
module aic_pseudo_cause_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  grp_irq_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk_i = ~clk_i;

  aic_pseudo_cause dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .grp_irq_i(grp_irq_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // monitor: compares every read against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (req_i && !we_i) begin
        n_run++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected read: actual %h expected none", rdata_o);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rdata_o !== e) begin
            n_fail++;
            $display("FAIL %s: rdata actual %h expected %h", t, rdata_o, e);
          end
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t,
                    input logic [2:0] evt = 3'b000);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; grp_irq_i = evt;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk_i);
    req_i = 1'b0; grp_irq_i = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] g);
    @(negedge clk_i);
    grp_irq_i = g;
    @(negedge clk_i);
    grp_irq_i = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk_i);
    #2;
    n_run++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", t, irq_o, e);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk_irq(1'b0, "R1 irq after reset");
    rd(2'd0, 32'h0, "R1 summary after reset");
    rd(2'd1, 32'hFFFF_FFFF, "R1 mask after reset");

    pulse(3'b001);
    rd(2'd0, 32'h1, "R2 rx bit");
    rd(2'd0, 32'h0, "R3 cleared by read");

    pulse(3'b110);
    chk_irq(1'b0, "R7 fully masked with pending");
    rd(2'd0, 32'h6, "R2 tx and misc bits");

    wr(2'd1, 32'hFFFF_FFF8);
    rd(2'd1, 32'hFFFF_FFF8, "R5 mask readback");
    chk_irq(1'b0, "R6 unmasked but empty");

    pulse(3'b100);
    chk_irq(1'b1, "R6 misc raises line");
    rd(2'd0, 32'h4, "R3 misc read");
    chk_irq(1'b0, "R6 line drops after clear");

    pulse(3'b001);
    rd(2'd0, 32'h1, "R4 read with coincident tx", 3'b010);
    rd(2'd0, 32'h2, "R4 coincident event kept");

    wr(2'd1, 32'hFFFF_FFFD);
    pulse(3'b001);
    chk_irq(1'b0, "R8 rx masked");
    pulse(3'b010);
    chk_irq(1'b1, "R8 tx unmasked");
    rd(2'd0, 32'h3, "R8 both pending");

    wr(2'd1, 32'h0000_0007);
    pulse(3'b100);
    chk_irq(1'b0, "R8 upper zeros do not unmask");
    rd(2'd0, 32'h4, "R8 misc pending");

    pulse(3'b001);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h1, "R9 write to summary ignored");
    wr(2'd0, 32'h0000_0007);
    rd(2'd0, 32'h0, "R9 write does not set");

    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0);
    rd(2'd1, 32'h0000_0007, "R10 mask untouched by unmapped write");
    rd(2'd3, 32'h0, "R10 unmapped read");
    rd(2'd2, 32'h0, "R10 unmapped read");

    @(negedge clk_i);
    grp_irq_i = 3'b001;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 2'd0;
    exp_q.push_back(32'h1); tag_q.push_back("R3 held level reappears");
    @(negedge clk_i);
    exp_q.push_back(32'h1); tag_q.push_back("R3 held level reappears");
    @(negedge clk_i);
    req_i = 1'b0; grp_irq_i = '0;
    rd(2'd0, 32'h1, "R3 last held edge");
    rd(2'd0, 32'h0, "R3 clear after release");

    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule